// File: doc/BRIEF.md
# Stipple and Blit Pixel Engine

This block accelerates drawing into an 8-bit-per-pixel frame buffer. Software issues each drawing command as two 32-bit bus writes. The first write, at an address with bit 2 clear, loads a colour register. The second write, at an address with bit 2 set, starts an operation. The destination pixel index of that operation is packed into the bus address of the write.

The `bus_mode` input selects how the data word of the triggering write is read. In stipple mode the word is a 32-pixel mask, and every pixel whose mask bit is set receives the colour. In blit mode the word holds a source pixel address and a run length. A source value of all ones turns the run into a solid fill with the colour. Any other source value gives a copy from the source run.

The engine handles one pixel per clock inside a pixel memory that has one write port and two read ports. One read port serves the engine. The other is a separate observation port for a neighbouring reader. The engine raises `busy` while it works and holds off any further access until it finishes.

Top module: `stipple_blit_engine`

## Requirements
- R1: An accepted write with bus_addr[2]=0 loads the colour register, whose low 8 bits are the pixel colour. It starts no operation, so `busy` stays 0 in the following cycle.
- R2: An accepted write with bus_addr[2]=1 starts an operation, and `busy` is 1 in the following cycle. The destination index is bus_addr[22:3] taken modulo the pixel memory size, and pixel addresses wrap around the top of memory.
- R3: Stipple mode (bus_mode=0) treats bus_wdata as a mask. Bit 31 maps to destination+0 and bit 0 maps to destination+31. Pixels whose bit is 1 receive the colour, and pixels whose bit is 0 keep their value.
- R4: Blit mode (bus_mode=1) takes the source index from bus_wdata[23:0] (modulo the memory size) and the run length from bus_wdata[28:24]+1, so a run is 1 to 32 pixels.
- R5: In blit mode, a source field of 0xFFFFFF fills the run with the colour instead of copying.
- R6: A copy runs in ascending order and reads each source pixel before it writes the destination pixel. Overlapping ranges therefore give the result of a pixel-by-pixel forward loop: a destination one above the source replicates the first source pixel.
- R7: `bus_rdata` is always 0, and a read (bus_write=0) starts nothing.
- R8: An access whose byte enables are not all four set is ignored. It changes neither the colour nor the memory, and it does not start an operation.
- R9: A stipple operation keeps `busy` high for 33 cycles, and a blit of L pixels keeps it high for L+1 cycles.
- R10: `bus_ready` is 0 while `busy` is 1. An access presented in that time waits and is taken only after the engine is idle.
- R11: After reset, `busy` is 0 and `bus_ready` is 1.
- R12: `obs_data` returns the pixel at `obs_addr` one clock after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Access request |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | BUS_AW | Byte address; bit 2 selects trigger, bits [22:3] hold the destination |
| bus_be | input | 4 | Byte enables; all four must be set |
| bus_wdata | input | 32 | Colour, mask or blit descriptor |
| bus_mode | input | 1 | 0 = stipple, 1 = blit, used on trigger writes |
| bus_ready | output | 1 | Access taken at the clock edge when high together with bus_valid |
| bus_rdata | output | 32 | Read data, always zero |
| busy | output | 1 | Operation in progress |
| obs_addr | input | PIX_AW | Observation read address |
| obs_data | output | PIX_W | Observation read data, one cycle latency |

## Verification
The checker watches every cycle for these bus rules:
- a colour load, a read or a partial-width access never raises `busy`;
- an accepted trigger always raises it;
- `bus_ready` is never high while `busy` is;
- a busy period never exceeds the stipple length.

Some behaviour only the bench scenarios can show, by comparing a computed pixel model against the memory:
- which pixels a mask touches;
- the fill and copy results across all run lengths;
- overlapping copies;
- address wrap and source masking;
- the exact busy duration for each operation.

// File: rtl/pxe_pkg.sv
package pxe_pkg;

  localparam int PXE_IDX_W  = 20;
  localparam int PXE_IDX_LSB = 3;
  localparam int PXE_SRC_W  = 24;
  localparam int PXE_RUN_W  = 5;
  localparam int PXE_MASK_W = 32;

  typedef enum logic [1:0] {
    PXE_STIP = 2'd0,
    PXE_FILL = 2'd1,
    PXE_COPY = 2'd2
  } pxe_op_e;

  typedef struct packed {
    pxe_op_e                 op;
    logic [PXE_IDX_W-1:0]    dst;
    logic [PXE_SRC_W-1:0]    src;
    logic [PXE_RUN_W-1:0]    last;
    logic [PXE_MASK_W-1:0]   mask;
  } pxe_cmd_t;

endpackage

// File: rtl/pxe_cmd_decode.sv
module pxe_cmd_decode
  import pxe_pkg::*;
#(
  parameter int BUS_AW = 23,
  parameter int DATA_W = 32,
  parameter int PIX_W  = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                valid,
  input  logic                write,
  input  logic [BUS_AW-1:0]   addr,
  input  logic [DATA_W/8-1:0] be,
  input  logic [DATA_W-1:0]   wdata,
  input  logic                mode,
  input  logic                busy,
  output logic                ready,
  output logic [PIX_W-1:0]    colour,
  output logic                start,
  output pxe_cmd_t            cmd
);

  localparam int TRIG_BIT = 2;

  logic full_word;
  logic accept;
  logic is_fill;

  assign ready     = ~busy;
  assign full_word = &be;
  assign accept    = valid & write & full_word & ready;
  assign start     = accept & addr[TRIG_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      colour <= '0;
    end else if (accept && !addr[TRIG_BIT]) begin
      colour <= wdata[PIX_W-1:0];
    end
  end

  assign is_fill = (wdata[PXE_SRC_W-1:0] == {PXE_SRC_W{1'b1}});

  always_comb begin
    cmd.dst  = addr[PXE_IDX_LSB +: PXE_IDX_W];
    cmd.src  = wdata[PXE_SRC_W-1:0];
    cmd.mask = wdata[PXE_MASK_W-1:0];
    if (mode) begin
      cmd.op   = is_fill ? PXE_FILL : PXE_COPY;
      cmd.last = wdata[PXE_SRC_W +: PXE_RUN_W];
    end else begin
      cmd.op   = PXE_STIP;
      cmd.last = {PXE_RUN_W{1'b1}};
    end
  end

endmodule

// File: rtl/pxe_seq.sv
module pxe_seq
  import pxe_pkg::*;
#(
  parameter int PIX_AW = 10,
  parameter int PIX_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  pxe_cmd_t          cmd,
  input  logic [PIX_W-1:0]  colour,
  input  logic [PIX_W-1:0]  mem_q,
  output logic [PIX_AW-1:0] rd_addr,
  output logic              we,
  output logic [PIX_AW-1:0] wa,
  output logic [PIX_W-1:0]  wd,
  output logic              busy
);

  // stage 0: address generation and source read
  logic                   run;
  pxe_op_e                op;
  logic [PXE_RUN_W-1:0]   idx;
  logic [PXE_RUN_W-1:0]   last;
  logic [PXE_MASK_W-1:0]  mask;
  logic [PIX_AW-1:0]      dst;
  logic [PIX_AW-1:0]      src;
  logic [PIX_AW-1:0]      gen_addr;
  logic                   gen_v;

  // stage 1: pixel write
  logic                   act1;
  logic                   pend_v;
  logic                   pend_copy;
  logic [PIX_AW-1:0]      pend_addr;
  logic                   byp_v;
  logic [PIX_W-1:0]       byp_d;

  assign gen_addr = dst + PIX_AW'(idx);
  assign rd_addr  = src + PIX_AW'(idx);
  assign gen_v    = (op == PXE_STIP) ? mask[PXE_MASK_W-1] : 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      run  <= 1'b0;
      op   <= PXE_STIP;
      idx  <= '0;
      last <= '0;
      mask <= '0;
      dst  <= '0;
      src  <= '0;
    end else if (start) begin
      run  <= 1'b1;
      op   <= cmd.op;
      idx  <= '0;
      last <= cmd.last;
      mask <= cmd.mask;
      dst  <= cmd.dst[PIX_AW-1:0];
      src  <= cmd.src[PIX_AW-1:0];
    end else if (run) begin
      mask <= mask << 1;
      idx  <= idx + 1'b1;
      if (idx == last) run <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act1      <= 1'b0;
      pend_v    <= 1'b0;
      pend_copy <= 1'b0;
      pend_addr <= '0;
      byp_v     <= 1'b0;
      byp_d     <= '0;
    end else begin
      act1      <= run;
      pend_v    <= run & gen_v;
      pend_copy <= (op == PXE_COPY);
      pend_addr <= gen_addr;
      // read-first memory: forward a same-cycle write to the read result
      byp_v     <= we && (rd_addr == wa);
      byp_d     <= wd;
    end
  end

  assign we   = pend_v;
  assign wa   = pend_addr;
  assign wd   = pend_copy ? (byp_v ? byp_d : mem_q) : colour;
  assign busy = run | act1;

endmodule

// File: rtl/pxe_pixel_ram.sv
module pxe_pixel_ram #(
  parameter int AW = 10,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [DW-1:0] wd,
  input  logic [AW-1:0] ra,
  output logic [DW-1:0] rq,
  input  logic [AW-1:0] oa,
  output logic [DW-1:0] oq
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[wa] <= wd;
    rq <= mem[ra];
    oq <= mem[oa];
  end

endmodule

// File: rtl/stipple_blit_engine.sv
module stipple_blit_engine
  import pxe_pkg::*;
#(
  parameter int BUS_AW = 23,
  parameter int PIX_AW = 10,
  parameter int PIX_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [3:0]        bus_be,
  input  logic [31:0]       bus_wdata,
  input  logic              bus_mode,
  output logic              bus_ready,
  output logic [31:0]       bus_rdata,
  output logic              busy,
  input  logic [PIX_AW-1:0] obs_addr,
  output logic [PIX_W-1:0]  obs_data
);

  localparam int DATA_W = 32;

  logic              start;
  pxe_cmd_t          cmd;
  logic [PIX_W-1:0]  colour;
  logic [PIX_W-1:0]  mem_q;
  logic [PIX_AW-1:0] rd_addr;
  logic              we;
  logic [PIX_AW-1:0] wa;
  logic [PIX_W-1:0]  wd;

  assign bus_rdata = '0;

  pxe_cmd_decode #(
    .BUS_AW (BUS_AW),
    .DATA_W (DATA_W),
    .PIX_W  (PIX_W)
  ) dec_i (
    .clk    (clk),
    .rst    (rst),
    .valid  (bus_valid),
    .write  (bus_write),
    .addr   (bus_addr),
    .be     (bus_be),
    .wdata  (bus_wdata),
    .mode   (bus_mode),
    .busy   (busy),
    .ready  (bus_ready),
    .colour (colour),
    .start  (start),
    .cmd    (cmd)
  );

  pxe_seq #(
    .PIX_AW (PIX_AW),
    .PIX_W  (PIX_W)
  ) seq_i (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .cmd     (cmd),
    .colour  (colour),
    .mem_q   (mem_q),
    .rd_addr (rd_addr),
    .we      (we),
    .wa      (wa),
    .wd      (wd),
    .busy    (busy)
  );

  pxe_pixel_ram #(
    .AW (PIX_AW),
    .DW (PIX_W)
  ) ram_i (
    .clk (clk),
    .we  (we),
    .wa  (wa),
    .wd  (wd),
    .ra  (rd_addr),
    .rq  (mem_q),
    .oa  (obs_addr),
    .oq  (obs_data)
  );

endmodule

// File: rtl/pxe_chk.sv
module pxe_chk #(
  parameter int BUS_AW = 23
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_valid,
  input logic              bus_write,
  input logic [BUS_AW-1:0] bus_addr,
  input logic [3:0]        bus_be,
  input logic              bus_ready,
  input logic              busy
);

  localparam int MAX_BUSY = 33;

  logic [6:0] busy_len;
  logic       full_acc;

  assign full_acc = bus_valid && bus_write && (bus_be == 4'hF) && !busy;

  always_ff @(posedge clk) begin
    if (rst || !busy) busy_len <= '0;
    else              busy_len <= busy_len + 1'b1;
  end

  AST_COLOUR_NO_START: assert property (@(posedge clk) disable iff (rst)
    (full_acc && !bus_addr[2]) |=> !busy);                                  // R1
  AST_TRIGGER_STARTS: assert property (@(posedge clk) disable iff (rst)
    (full_acc && bus_addr[2]) |=> busy);                                    // R2
  AST_READ_NO_START: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && !bus_write && !busy) |=> !busy);                          // R7
  AST_PARTIAL_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && (bus_be != 4'hF) && !busy) |=> !busy);                    // R8
  AST_BUSY_BOUND: assert property (@(posedge clk) disable iff (rst)
    busy |-> (busy_len < 7'(MAX_BUSY)));                                    // R9
  AST_HOLD_OFF: assert property (@(posedge clk) disable iff (rst)
    busy |-> !bus_ready);                                                   // R10
  AST_RESET_IDLE: assert property (@(posedge clk)
    rst |=> (!busy && bus_ready));                                          // R11

endmodule

bind stipple_blit_engine pxe_chk #(.BUS_AW(BUS_AW)) chk_i (.*);

// File: tb/stipple_blit_engine_tb_top.sv
module stipple_blit_engine_tb_top;

  localparam int BUS_AW = 23;
  localparam int PIX_AW = 10;
  localparam int PIX_W  = 8;
  localparam int NPIX   = 1 << PIX_AW;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              bus_valid = 1'b0;
  logic              bus_write = 1'b0;
  logic [BUS_AW-1:0] bus_addr = '0;
  logic [3:0]        bus_be = 4'hF;
  logic [31:0]       bus_wdata = '0;
  logic              bus_mode = 1'b0;
  logic              bus_ready;
  logic [31:0]       bus_rdata;
  logic              busy;
  logic [PIX_AW-1:0] obs_addr = '0;
  logic [PIX_W-1:0]  obs_data;

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] model [NPIX];
  logic [7:0] mcol = 8'h00;

  always #5 clk = ~clk;

  stipple_blit_engine #(.BUS_AW(BUS_AW), .PIX_AW(PIX_AW), .PIX_W(PIX_W)) dut_i (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
    .bus_mode(bus_mode), .bus_ready(bus_ready), .bus_rdata(bus_rdata),
    .busy(busy), .obs_addr(obs_addr), .obs_data(obs_data)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // one bus access; returns at the negedge after the edge that took it
  task automatic access(input logic [BUS_AW-1:0] a, input logic [31:0] d,
                        input logic m, input logic [3:0] be, input logic wr);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = wr; bus_addr = a; bus_wdata = d;
    bus_mode = m; bus_be = be;
    while (!bus_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0; bus_be = 4'hF;
  endtask

  function automatic logic [BUS_AW-1:0] taddr(input logic [19:0] dst);
    return {dst, 3'b100};
  endfunction

  task automatic set_colour(input logic [31:0] c);
    access(23'h0000A8 & ~23'h4, c, 1'b0, 4'hF, 1'b1);
    mcol = c[7:0];
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (busy) begin n++; @(negedge clk); end
  endtask

  task automatic stipple(input logic [19:0] dst, input logic [31:0] msk, output int n);
    access(taddr(dst), msk, 1'b0, 4'hF, 1'b1);
    wait_idle(n);
    for (int i = 0; i < 32; i++)
      if (msk[31-i]) model[(int'(dst) + i) % NPIX] = mcol;
  endtask

  task automatic blit(input logic [19:0] dst, input logic [31:0] d, output int n);
    int len;
    int s;
    access(taddr(dst), d, 1'b1, 4'hF, 1'b1);
    wait_idle(n);
    len = int'(d[28:24]) + 1;
    s = int'(d[23:0]);
    for (int i = 0; i < len; i++) begin
      if (d[23:0] == 24'hFFFFFF) model[(int'(dst) + i) % NPIX] = mcol;
      else model[(int'(dst) + i) % NPIX] = model[(s + i) % NPIX];
    end
  endtask

  function automatic logic [31:0] bdesc(input int len, input logic [23:0] src);
    return {3'b000, 5'(len - 1), src};
  endfunction

  task automatic compare_mem(input string req);
    int bad = 0;
    int first = -1;
    logic [7:0] fa = 8'h00;
    for (int i = 0; i < NPIX; i++) begin
      obs_addr = PIX_AW'(i);
      @(negedge clk);
      if (obs_data !== model[i]) begin
        bad++;
        if (first < 0) begin first = i; fa = obs_data; end
      end
    end
    if (bad != 0) chk(1'b0, $sformatf("%s pixel %0d", req, first), fa, model[first]);
    else chk(1'b1, req, 0, 0);
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    int n;
    logic [31:0] masks [4];
    masks[0] = 32'hA5F0_0F5A; masks[1] = 32'hFFFF_FFFF;
    masks[2] = 32'h0000_0001; masks[3] = 32'h0000_0000;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(busy == 1'b0, "R11 busy after reset", busy, 0);
    chk(bus_ready == 1'b1, "R11 ready after reset", bus_ready, 1);

    // R1: colour write starts nothing
    set_colour(32'h1234_5600);
    chk(busy == 1'b0, "R1 colour write no start", busy, 0);

    // clear memory with fills (R5)
    for (int k = 0; k < NPIX / 32; k++) blit(20'(k * 32), bdesc(32, 24'hFFFFFF), n);
    compare_mem("R5 clear fill");

    // seed distinct values one pixel at a time (R3)
    for (int i = 0; i < 64; i++) begin
      set_colour({24'hFEDCBA, 8'(i * 7 + 3)});
      stipple(20'(100 + i), 32'h8000_0000, n);
    end
    compare_mem("R3 seed single pixels");

    // stipple mask patterns, high colour bytes must not matter (R3, R9)
    for (int p = 0; p < 4; p++) begin
      set_colour({8'hC3, 16'h0F0F, 8'(8'h50 + p)});
      stipple(20'(200 + p * 40), masks[p], n);
      chk(n == 33, $sformatf("R9 stipple busy pattern %0d", p), n, 33);
      compare_mem($sformatf("R3 stipple pattern %0d", p));
    end

    // fill sweep over every length (R4, R5, R9)
    for (int L = 1; L <= 32; L++) begin
      set_colour({24'hABCDEF, 8'(L + 8'h80)});
      blit(20'(360 + L * 13), bdesc(L, 24'hFFFFFF), n);
      chk(n == L + 1, $sformatf("R9 fill busy len %0d", L), n, L + 1);
    end
    compare_mem("R4 R5 fill length sweep");

    // plain copy (R6, R9)
    blit(20'd800, bdesc(20, 24'd100), n);
    chk(n == 21, "R9 copy busy len 20", n, 21);
    compare_mem("R6 copy disjoint");

    // overlapping forward: replicates first source pixel (R6)
    blit(20'd101, bdesc(8, 24'd100), n);
    compare_mem("R6 copy dst above src");
    for (int i = 0; i < 8; i++)
      chk(model[101 + i] == model[100], "R6 replicate model", model[101 + i], model[100]);

    // overlapping backward (R6)
    blit(20'd117, bdesc(10, 24'd120), n);
    compare_mem("R6 copy dst below src");

    // source masking: not the fill marker (R4)
    blit(20'd850, bdesc(4, 24'hFFFFFE), n);
    compare_mem("R4 source masked");

    // destination address high bits and wrap (R2)
    set_colour(32'h0000_0077);
    blit(20'hABFFC, bdesc(8, 24'hFFFFFF), n);
    compare_mem("R2 dest wrap");

    // partial byte enables ignored (R8)
    access(taddr(20'd900), bdesc(16, 24'hFFFFFF), 1'b1, 4'b0111, 1'b1);
    chk(busy == 1'b0, "R8 partial trigger no start", busy, 0);
    access(23'h000010, 32'h0000_0011, 1'b0, 4'b1110, 1'b1);
    blit(20'd910, bdesc(4, 24'hFFFFFF), n);
    compare_mem("R8 partial ignored colour and memory");

    // reads return zero and start nothing (R7)
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = taddr(20'd950); bus_mode = 1'b1;
    bus_wdata = bdesc(8, 24'hFFFFFF);
    chk(bus_rdata == 32'h0, "R7 read data zero", bus_rdata, 0);
    @(negedge clk);
    bus_valid = 1'b0;
    chk(busy == 1'b0, "R7 read no start", busy, 0);
    compare_mem("R7 read memory unchanged");

    // held-off trigger (R10)
    set_colour(32'h0000_0033);
    access(taddr(20'd960), 32'hFFFF_0000, 1'b0, 4'hF, 1'b1);
    for (int i = 0; i < 16; i++) model[960 + i] = mcol;
    chk(bus_ready == 1'b0, "R10 ready low while busy", bus_ready, 0);
    blit(20'd970, bdesc(12, 24'd960), n);
    compare_mem("R10 queued copy after stipple");

    // observation latency (R12)
    @(negedge clk);
    obs_addr = PIX_AW'(960);
    @(negedge clk);
    chk(obs_data == 8'h33, "R12 obs one cycle", obs_data, 8'h33);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule